// File: doc/BRIEF.md
# NMEA Sentence Field Splitter

This block takes the serial output of a GPS receiver on a single wire and turns it into a stream of framed fields. A built-in receiver recovers 8N1 characters at 4800 bit/s from a system clock of known frequency. A parser then finds the boundaries of each sentence and each comma-separated field inside it.

Downstream logic sees three kinds of output. Each content character comes with the index of the field it belongs to. Each field is bracketed by a start strobe and an end strobe, and this holds for fields with no characters too, so field positions never shift. A done strobe marks each sentence that ends cleanly. Framing errors and malformed line endings are reported as pulses, and the sentence in progress is dropped. The checksum is passed through as ordinary characters of the last field.

Top module: `nmea_field_splitter`

## Requirements
- R1: The receiver decodes 8N1 frames, LSB first, at `BAUD` bit/s from a `CLK_HZ` clock with 16x oversampling, and it confirms the start bit at its middle.
- R2: A `$` (0x24) opens a sentence and raises `fld_start` with `fld_idx` = 0. Bytes received while no sentence is open raise no strobe.
- R3: Inside a sentence, every byte other than `$`, `,` (0x2C), CR (0x0D) and LF (0x0A) raises `chr_vld` for one cycle, with the byte on `chr_byte` and the current field on `fld_idx`.
- R4: A comma raises `fld_end` with the current index. In the next cycle it raises `fld_start` with the index plus one. An empty field therefore gives a start/end pair with no `chr_vld` between them.
- R5: The field index saturates at 31. Further commas end and start field 31 again.
- R6: A CR raises `fld_end` for the current field. An LF that directly follows that CR raises `sent_done`.
- R7: `sent_long` is high together with `sent_done` when the sentence, counting `$`, CR and LF, is longer than 82 bytes. It is low for a sentence of exactly 82 bytes.
- R8: A `$` inside an open sentence drops that sentence without `sent_done` and starts a new one at index 0.
- R9: A CR followed by any byte other than LF, or an LF without a preceding CR, raises `malformed` and drops the sentence without `sent_done`. Later bytes are ignored until the next `$`.
- R10: A stop bit read as 0 raises `frame_err` and drops any open sentence. The receiver then waits for the line to go high before it looks for a new start bit.
- R11: After reset all strobes are low and `fld_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| rx | input | 1 | Serial data from the GPS receiver, idle high |
| chr_vld | output | 1 | Content character strobe |
| chr_byte | output | 8 | Content character |
| fld_idx | output | 5 | Field index that goes with the current strobe |
| fld_start | output | 1 | Field start strobe |
| fld_end | output | 1 | Field end strobe |
| sent_done | output | 1 | Sentence completed with CR LF |
| sent_long | output | 1 | Sentence exceeded 82 bytes, valid with `sent_done` |
| frame_err | output | 1 | Stop bit error pulse |
| malformed | output | 1 | Bad line ending pulse |

## Verification
The hardest cases to reach from the ports are the length boundary and index saturation, because both need long sentences sent bit by bit over the serial line. The bench overrides the clock frequency so that one bit lasts 48 cycles. It then sends sentences of exactly 82 and 83 bytes, and a sentence with 33 commas that pushes the index past 31. A framing error in the middle of a sentence is produced by sending one character with a low stop bit and holding the line low until that bit ends.

// File: rtl/nmea_field_splitter.sv
module nmea_field_splitter #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int BAUD    = 4800,
  parameter int MAX_LEN = 82,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  output logic             chr_vld,
  output logic [7:0]       chr_byte,
  output logic [IDX_W-1:0] fld_idx,
  output logic             fld_start,
  output logic             fld_end,
  output logic             sent_done,
  output logic             sent_long,
  output logic             frame_err,
  output logic             malformed
);
  localparam int DIV = (CLK_HZ / (BAUD * 16) > 0) ? CLK_HZ / (BAUD * 16) : 1;
  localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LW  = $clog2(MAX_LEN + 2);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} rx_st_t;

  logic [1:0]    sync;
  logic          rx_s;
  logic [DW-1:0] div_cnt;
  logic          tick;
  rx_st_t        st;
  logic [3:0]    tcnt;
  logic [2:0]    bcnt;
  logic [7:0]    sr;
  logic          byte_vld, ferr;

  assign rx_s = sync[1];
  assign tick = (div_cnt == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      div_cnt <= '0;
    end else begin
      sync    <= {sync[0], rx};
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; bcnt <= '0; sr <= '0;
      byte_vld <= 1'b0; ferr <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      ferr     <= 1'b0;
      if (st == S_HOLD) begin
        if (rx_s) st <= S_IDLE;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin st <= S_START; tcnt <= '0; end
          S_START:
            if (tcnt == 4'd7) begin
              tcnt <= '0; bcnt <= '0;
              st   <= rx_s ? S_IDLE : S_DATA;
            end else tcnt <= tcnt + 1'b1;
          S_DATA:
            if (tcnt == 4'd15) begin
              tcnt <= '0;
              sr   <= {rx_s, sr[7:1]};
              bcnt <= bcnt + 1'b1;
              if (bcnt == 3'd7) st <= S_STOP;
            end else tcnt <= tcnt + 1'b1;
          S_STOP:
            if (tcnt == 4'd15) begin
              tcnt <= '0;
              if (rx_s) begin byte_vld <= 1'b1; st <= S_IDLE; end
              else begin ferr <= 1'b1; st <= S_HOLD; end
            end else tcnt <= tcnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic             in_s, cr_seen, pend;
  logic [IDX_W-1:0] fidx;
  logic [LW-1:0]    len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_s <= 1'b0; cr_seen <= 1'b0; pend <= 1'b0;
      fidx <= '0; len <= '0;
      chr_vld <= 1'b0; chr_byte <= '0; fld_idx <= '0;
      fld_start <= 1'b0; fld_end <= 1'b0; sent_done <= 1'b0;
      sent_long <= 1'b0; frame_err <= 1'b0; malformed <= 1'b0;
    end else begin
      chr_vld <= 1'b0; fld_start <= 1'b0; fld_end <= 1'b0;
      sent_done <= 1'b0; sent_long <= 1'b0;
      frame_err <= 1'b0; malformed <= 1'b0;
      if (ferr) begin
        frame_err <= 1'b1;
        in_s <= 1'b0; cr_seen <= 1'b0; pend <= 1'b0;
      end else if (pend) begin
        pend      <= 1'b0;
        fld_start <= 1'b1;
        fld_idx   <= fidx;
      end else if (byte_vld) begin
        if (sr == 8'h24) begin
          in_s <= 1'b1; cr_seen <= 1'b0;
          fidx <= '0; len <= LW'(1);
          fld_start <= 1'b1; fld_idx <= '0;
        end else if (in_s) begin
          if (len <= LW'(MAX_LEN)) len <= len + 1'b1;
          if (cr_seen) begin
            in_s <= 1'b0; cr_seen <= 1'b0;
            if (sr == 8'h0A) begin
              sent_done <= 1'b1;
              sent_long <= (len >= LW'(MAX_LEN));
            end else malformed <= 1'b1;
          end else begin
            case (sr)
              8'h2C: begin
                fld_end <= 1'b1; fld_idx <= fidx; pend <= 1'b1;
                if (fidx != IDX_MAX) fidx <= fidx + 1'b1;
              end
              8'h0D: begin fld_end <= 1'b1; fld_idx <= fidx; cr_seen <= 1'b1; end
              8'h0A: begin malformed <= 1'b1; in_s <= 1'b0; end
              default: begin chr_vld <= 1'b1; chr_byte <= sr; fld_idx <= fidx; end
            endcase
          end
        end
      end
    end
  end
endmodule

module nmea_field_splitter_chk #(parameter int IDX_W = 5) (
  input logic             clk,
  input logic             rst_n,
  input logic             chr_vld,
  input logic [7:0]       chr_byte,
  input logic [IDX_W-1:0] fld_idx,
  input logic             fld_start,
  input logic             fld_end,
  input logic             sent_done,
  input logic             frame_err,
  input logic             malformed
);
  localparam logic [IDX_W-1:0] IMAX = '1;

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chr_vld, fld_start, fld_end, sent_done, frame_err, malformed}));

  p_no_delim_chr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_vld |-> (chr_byte != 8'h24 && chr_byte != 8'h2C &&
                 chr_byte != 8'h0D && chr_byte != 8'h0A));

  p_open_idx_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start && !$past(fld_end)) |-> (fld_idx == '0));

  p_comma_next_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start && $past(fld_end) && $past(fld_idx) != IMAX) |->
      (fld_idx == $past(fld_idx) + 1'b1));

  p_idx_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_start && $past(fld_end) && $past(fld_idx) == IMAX) |-> (fld_idx == IMAX));

  p_ferr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !(chr_vld || fld_start || fld_end || sent_done));
endmodule

bind nmea_field_splitter nmea_field_splitter_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_byte(chr_byte),
  .fld_idx(fld_idx), .fld_start(fld_start), .fld_end(fld_end),
  .sent_done(sent_done), .frame_err(frame_err), .malformed(malformed)
);

// File: tb/nmea_field_splitter_tb_top.sv
module nmea_field_splitter_tb_top;
  localparam int BIT_CYC = 48;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic chr_vld, fld_start, fld_end, sent_done, sent_long, frame_err, malformed;
  logic [7:0] chr_byte;
  logic [4:0] fld_idx;

  always #10 clk = ~clk;

  nmea_field_splitter #(.CLK_HZ(230400), .BAUD(4800)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx(rx), .chr_vld(chr_vld), .chr_byte(chr_byte),
    .fld_idx(fld_idx), .fld_start(fld_start), .fld_end(fld_end),
    .sent_done(sent_done), .sent_long(sent_long), .frame_err(frame_err),
    .malformed(malformed));

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  string cur_req = "R11";
  logic [16:0] expq[$];

  // event: {kind[2:0], idx[4:0], data[7:0], flag}
  function automatic logic [16:0] mk(int k, int idx, logic [7:0] d, bit f);
    return {3'(k), 5'(idx), d, f};
  endfunction

  function automatic string ktag(logic [16:0] e);
    case (e[16:14])
      3'd1: return "R3";
      3'd2: return (e[13:9] == 0) ? "R2" : "R4";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic observe(logic [16:0] got);
    logic [16:0] e;
    checks++;
    if (expq.size() == 0) begin
      failures++;
      $display("FAIL %s/%s unexpected event got=%h exp=none", cur_req, ktag(got), got);
    end else begin
      e = expq.pop_front();
      if (e !== got) begin
        failures++;
        $display("FAIL %s/%s got=%h exp=%h", cur_req, ktag(e), got, e);
      end
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    if (frame_err) observe(mk(5, 0, 0, 0));
    if (malformed) observe(mk(6, 0, 0, 0));
    if (fld_end)   observe(mk(3, fld_idx, 0, 0));
    if (fld_start) observe(mk(2, fld_idx, 0, 0));
    if (chr_vld)   observe(mk(1, fld_idx, chr_byte, 0));
    if (sent_done) observe(mk(4, 0, 0, sent_long));
  end

  bit m_in = 0, m_cr = 0;
  int m_idx = 0, m_len = 0;

  task automatic model(logic [7:0] b, bit good);
    if (!good) begin
      expq.push_back(mk(5, 0, 0, 0)); m_in = 0; m_cr = 0;
    end else if (b == 8'h24) begin
      expq.push_back(mk(2, 0, 0, 0)); m_in = 1; m_cr = 0; m_idx = 0; m_len = 1;
    end else if (m_in) begin
      if (m_cr) begin
        if (b == 8'h0A) expq.push_back(mk(4, 0, 0, (m_len + 1) > 82));
        else expq.push_back(mk(6, 0, 0, 0));
        m_in = 0; m_cr = 0;
      end else begin
        m_len++;
        if (b == 8'h2C) begin
          expq.push_back(mk(3, m_idx, 0, 0));
          if (m_idx < 31) m_idx++;
          expq.push_back(mk(2, m_idx, 0, 0));
        end else if (b == 8'h0D) begin
          expq.push_back(mk(3, m_idx, 0, 0)); m_cr = 1;
        end else if (b == 8'h0A) begin
          expq.push_back(mk(6, 0, 0, 0)); m_in = 0;
        end else expq.push_back(mk(1, m_idx, b, 0));
      end
    end
  endtask

  task automatic send(logic [7:0] b, bit good = 1'b1);
    model(b, good);
    @(negedge clk) rx = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    rx = good;
    repeat (BIT_CYC) @(negedge clk);
    rx = 1'b1;
    repeat (good ? BIT_CYC : 2 * BIT_CYC) @(negedge clk);
  endtask

  task automatic send_str(string s);
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  task automatic send_rep(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) send(b);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({chr_vld, fld_start, fld_end, sent_done, sent_long, frame_err, malformed} !== 7'b0
        || fld_idx !== 5'd0) begin
      failures++;
      $display("FAIL R11 reset outputs got=%b/%0d exp=0/0",
               {chr_vld, fld_start, fld_end, sent_done, sent_long, frame_err, malformed}, fld_idx);
    end
    cur_req = "R2";  send_str("ab,\r\n");
    cur_req = "R1";  send_str("$GPA,1,,2*3F\r\n");
    cur_req = "R8";  send_str("$X,Y$Z,\r\n");
    cur_req = "R9";  send_str("$Q,1\rZ"); send_str("$R\n"); send_str("k");
    cur_req = "R10"; send_str("$S"); send(8'h41, 1'b0); send_str("$T\r\n");
    cur_req = "R5";  send("$"); send_rep(8'h2C, 33); send_str("\r\n");
    cur_req = "R7";  send("$"); send_rep(8'h58, 79); send_str("\r\n");
    send("$"); send_rep(8'h58, 80); send_str("\r\n");
    repeat (4 * BIT_CYC) @(negedge clk);
    cur_req = "R6";
    checks++;
    if (expq.size() != 0) begin
      failures++;
      $display("FAIL R6 missing events got=%0d exp=0", expq.size());
    end
    finish_run();
  end
endmodule